// File: doc/BRIEF.md
# Reorder Buffer Commit Controller

This block sits at the back end of an out-of-order pipeline for a single hardware thread. It owns a circular reorder buffer. Instructions are allocated at the tail in program order and marked complete out of order by execution. The controller retires them from the head, in order, several per cycle. Retirement stops at the first entry that has not completed.

Instructions that must not run speculatively are held back until they become the oldest entry. At that point the controller publishes their sequence number once, so that the issue logic can release them. Retirement waits until such an instruction reports completion.

A full flush request empties the buffer from the tail at a bounded number of entries per cycle. A trap request parks the thread until earlier stores have drained and a programmable delay has run out, and then starts the same flush. A fetch-side trap request blocks new allocation and lets the buffer drain by normal retirement. Earlier stages see the free-entry count together with a strobe that marks the cycles in which it moved. A single activity flag tells the rest of the core whether the unit is idle.

Top module: `rob_commit_ctrl`

## Requirements
- R1: In each cycle where the thread state is running or fetch-trap-pending, the controller retires the longest run of completed entries starting at the head, capped at COMMIT_WIDTH (default 2). It presents the count on `retire_cnt` and the sequence number of the oldest retired entry on `retire_seq`; the remaining entries follow in consecutive order.
- R2: When the head entry is marked non-speculative and has not completed, `retire_cnt` is 0. No release is issued for a non-speculative entry until it is the head.
- R3: Each non-speculative entry produces exactly one `nsr_valid` pulse, carrying its sequence number on `nsr_seq`. Two pulses never occur on consecutive cycles.
- R4: After `squash_req` is accepted the state is squashing (2). Each following cycle removes min(SQUASH_WIDTH, occupancy) entries from the tail (default SQUASH_WIDTH 3). On the edge that removes the last entry, the state becomes idle.
- R5: `thread_state` uses the encoding idle=0, running=1, squashing=2, trap-pending=3, fetch-trap-pending=4. No other value appears. Reset gives idle with 16 free entries.
- R6: `alloc_ok` is high only when `alloc_cnt` is non-zero, `alloc_cnt` does not exceed `free_cnt`, the state is idle or running, and no request input is high. Accepted entries take consecutive sequence numbers, starting at `alloc_seq` and at slot `alloc_idx`.
- R7: In trap-pending nothing is retired and nothing is allocated. The thread leaves trap-pending only in a cycle where `stores_drained` is high.
- R8: `free_upd` is high in exactly those cycles in which `free_cnt` differs from its value in the previous cycle.
- R9: A trap accepted with `trap_lat` = L and with `stores_drained` held high reaches squashing on the (L+1)th clock edge after the edge that accepted it.
- R10: In fetch-trap-pending, allocation is refused and retirement continues. When the buffer empties, the state returns to idle.
- R11: `active` is low only when the buffer is empty and the state is idle (no squash or trap in progress).
- R12: `squash_req`, `trap_req` and `ftrap_req` are acted on only in idle or running, with priority squash > trap > fetch-trap. In any other state they are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_cnt | input | ACNT_W | Number of instructions offered for allocation this cycle |
| alloc_nonspec | input | ALLOC_WIDTH | Per-slot flag: the offered instruction is non-speculative |
| alloc_ok | output | 1 | Offered instructions are accepted at this edge |
| alloc_idx | output | IDX_W | Buffer slot of the first offered instruction |
| alloc_seq | output | SEQ_W | Sequence number given to the first offered instruction |
| cmpl_valid | input | 1 | An entry has completed execution |
| cmpl_idx | input | IDX_W | Slot of the completed entry |
| retire_cnt | output | RCNT_W | Entries retiring at the coming edge |
| retire_seq | output | SEQ_W | Sequence number of the head entry |
| nsr_valid | output | 1 | Non-speculative release pulse |
| nsr_seq | output | SEQ_W | Sequence number being released |
| squash_req | input | 1 | Flush the whole buffer |
| trap_req | input | 1 | Trap or interrupt recognised |
| trap_lat | input | LAT_W | Delay in cycles before a trap flush may begin |
| stores_drained | input | 1 | All earlier stores have written back |
| ftrap_req | input | 1 | Fetch-side trap: stop allocating and drain |
| free_cnt | output | OCC_W | Free buffer entries |
| free_upd | output | 1 | Free count changed this cycle |
| thread_state | output | 3 | Thread state code |
| active | output | 1 | Controller has work in hand |

## Verification
The bound checker watches several things on every cycle: the retire cap, the stall of retirement behind an unreleased head, the spacing of release pulses, the bounded rate of squash removal, the hold in trap-pending while stores are outstanding, the link between `free_upd` and a moving free count, and the rule that an inactive unit has an empty buffer.

Other behaviours only show up across whole scenarios. The scoreboard checks program order and sequence numbering end to end. The scenarios also cover the exact cycle at which a trap turns into a flush for a given latency, release of a non-speculative entry only once it reaches the head, refusal of an allocation that would overflow by one entry, and requests arriving during a flush being ignored.

// File: rtl/rob_commit_pkg.sv
package rob_commit_pkg;

  typedef enum logic [2:0] {
    TS_IDLE   = 3'd0,
    TS_RUN    = 3'd1,
    TS_SQUASH = 3'd2,
    TS_TRAP   = 3'd3,
    TS_FTRAP  = 3'd4
  } thr_state_e;

  // States in which new work (allocation, requests) is taken.
  function automatic logic takes_new_work(thr_state_e s);
    return (s == TS_IDLE) || (s == TS_RUN);
  endfunction

  // States in which the head may retire.
  function automatic logic may_retire(thr_state_e s);
    return (s == TS_RUN) || (s == TS_FTRAP);
  endfunction

endpackage

// File: rtl/rob_retire_scan.sv
module rob_retire_scan #(
  parameter int DEPTH        = 16,
  parameter int COMMIT_WIDTH = 2,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int OCC_W  = IDX_W + 1,
  localparam int CNT_W  = $clog2(COMMIT_WIDTH + 1)
) (
  input  logic             enable,
  input  logic [IDX_W-1:0] head_idx,
  input  logic [OCC_W-1:0] occ,
  input  logic [DEPTH-1:0] done_vec,
  output logic [CNT_W-1:0] retire_n
);

  logic             stop;
  logic [IDX_W-1:0] slot;

  // Count the completed run from the head, cut at the first gap.
  always_comb begin
    retire_n = '0;
    stop     = !enable;
    slot     = head_idx;
    for (int i = 0; i < COMMIT_WIDTH; i++) begin
      slot = head_idx + IDX_W'(i);
      if (!stop && (OCC_W'(i) < occ) && done_vec[slot])
        retire_n = retire_n + CNT_W'(1);
      else
        stop = 1'b1;
    end
  end

endmodule

// File: rtl/rob_squash_step.sv
module rob_squash_step #(
  parameter int SQUASH_WIDTH = 3,
  parameter int OCC_W        = 5
) (
  input  logic             en,
  input  logic [OCC_W-1:0] occ,
  output logic [OCC_W-1:0] remove_n
);

  function automatic logic [OCC_W-1:0] clip_rate(logic [OCC_W-1:0] have);
    return (have < OCC_W'(SQUASH_WIDTH)) ? have : OCC_W'(SQUASH_WIDTH);
  endfunction

  assign remove_n = en ? clip_rate(occ) : '0;

endmodule

// File: rtl/rob_trap_timer.sv
module rob_trap_timer #(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LAT_W-1:0] load_val,
  input  logic             run,
  output logic             expired
);

  logic [LAT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (run && (cnt_q != '0))
      cnt_q <= cnt_q - LAT_W'(1);
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/rob_commit_ctrl.sv
module rob_commit_ctrl
  import rob_commit_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int COMMIT_WIDTH = 2,
  parameter int ALLOC_WIDTH  = 2,
  parameter int SQUASH_WIDTH = 3,
  parameter int SEQ_W        = 8,
  parameter int LAT_W        = 4,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int PTR_W  = IDX_W + 1,
  localparam int OCC_W  = IDX_W + 1,
  localparam int ACNT_W = $clog2(ALLOC_WIDTH + 1),
  localparam int RCNT_W = $clog2(COMMIT_WIDTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ACNT_W-1:0]      alloc_cnt,
  input  logic [ALLOC_WIDTH-1:0] alloc_nonspec,
  output logic                   alloc_ok,
  output logic [IDX_W-1:0]       alloc_idx,
  output logic [SEQ_W-1:0]       alloc_seq,
  input  logic                   cmpl_valid,
  input  logic [IDX_W-1:0]       cmpl_idx,
  output logic [RCNT_W-1:0]      retire_cnt,
  output logic [SEQ_W-1:0]       retire_seq,
  output logic                   nsr_valid,
  output logic [SEQ_W-1:0]       nsr_seq,
  input  logic                   squash_req,
  input  logic                   trap_req,
  input  logic [LAT_W-1:0]       trap_lat,
  input  logic                   stores_drained,
  input  logic                   ftrap_req,
  output logic [OCC_W-1:0]       free_cnt,
  output logic                   free_upd,
  output logic [2:0]             thread_state,
  output logic                   active
);

  // ---------------- state ----------------
  thr_state_e       state_q, state_d;
  logic [PTR_W-1:0] head_q, tail_q;
  logic [SEQ_W-1:0] seq_next_q;
  logic [DEPTH-1:0] done_q, nonspec_q, rel_q;
  logic [SEQ_W-1:0] seq_mem [DEPTH];
  logic             nsr_valid_q;
  logic [SEQ_W-1:0] nsr_seq_q;
  logic             free_upd_q;

  // ---------------- named internal events ----------------
  logic [OCC_W-1:0]  occ, occ_next, squash_n;
  logic [IDX_W-1:0]  head_idx, tail_idx;
  logic [RCNT_W-1:0] retire_n;
  logic [ACNT_W-1:0] alloc_n;
  logic              any_req, alloc_fits, nsr_fire, trap_take, trap_expired;

  assign head_idx = head_q[IDX_W-1:0];
  assign tail_idx = tail_q[IDX_W-1:0];
  assign occ      = tail_q - head_q;
  assign free_cnt = OCC_W'(DEPTH) - occ;

  rob_retire_scan #(.DEPTH(DEPTH), .COMMIT_WIDTH(COMMIT_WIDTH)) u_scan (
    .enable   (may_retire(state_q)),
    .head_idx (head_idx),
    .occ      (occ),
    .done_vec (done_q),
    .retire_n (retire_n)
  );

  rob_squash_step #(.SQUASH_WIDTH(SQUASH_WIDTH), .OCC_W(OCC_W)) u_sq (
    .en       (state_q == TS_SQUASH),
    .occ      (occ),
    .remove_n (squash_n)
  );

  assign trap_take = takes_new_work(state_q) && !squash_req && trap_req;

  rob_trap_timer #(.LAT_W(LAT_W)) u_trap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (trap_take),
    .load_val (trap_lat),
    .run      (state_q == TS_TRAP),
    .expired  (trap_expired)
  );

  assign any_req    = squash_req || trap_req || ftrap_req;
  assign alloc_fits = OCC_W'(alloc_cnt) <= free_cnt;
  assign alloc_ok   = takes_new_work(state_q) && !any_req &&
                      (alloc_cnt != '0) && alloc_fits;
  assign alloc_n    = alloc_ok ? alloc_cnt : '0;
  assign occ_next   = occ + OCC_W'(alloc_n) - OCC_W'(retire_n) - squash_n;

  assign nsr_fire = may_retire(state_q) && (occ != '0) &&
                    nonspec_q[head_idx] && !done_q[head_idx] && !rel_q[head_idx];

  // ---------------- next state ----------------
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TS_IDLE, TS_RUN: begin
        if (squash_req)          state_d = TS_SQUASH;
        else if (trap_req)       state_d = TS_TRAP;
        else if (ftrap_req)      state_d = TS_FTRAP;
        else if (occ_next == '0) state_d = TS_IDLE;
        else                     state_d = TS_RUN;
      end
      TS_SQUASH: state_d = (occ_next == '0) ? TS_IDLE : TS_SQUASH;
      TS_TRAP:   state_d = (trap_expired && stores_drained) ? TS_SQUASH : TS_TRAP;
      TS_FTRAP:  state_d = (occ_next == '0) ? TS_IDLE : TS_FTRAP;
      default:   state_d = TS_IDLE;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= TS_IDLE;
      head_q      <= '0;
      tail_q      <= '0;
      seq_next_q  <= '0;
      done_q      <= '0;
      nonspec_q   <= '0;
      rel_q       <= '0;
      nsr_valid_q <= 1'b0;
      nsr_seq_q   <= '0;
      free_upd_q  <= 1'b0;
      for (int k = 0; k < DEPTH; k++) seq_mem[k] <= '0;
    end else begin
      state_q     <= state_d;
      head_q      <= head_q + PTR_W'(retire_n);
      tail_q      <= tail_q + PTR_W'(alloc_n) - PTR_W'(squash_n);
      seq_next_q  <= seq_next_q + SEQ_W'(alloc_n);
      free_upd_q  <= (occ_next != occ);
      nsr_valid_q <= nsr_fire;
      if (nsr_fire) begin
        rel_q[head_idx] <= 1'b1;
        nsr_seq_q       <= seq_mem[head_idx];
      end
      if (cmpl_valid && (state_q != TS_SQUASH))
        done_q[cmpl_idx] <= 1'b1;
      for (int j = 0; j < ALLOC_WIDTH; j++) begin
        if (ACNT_W'(j) < alloc_n) begin
          done_q[tail_idx + IDX_W'(j)]    <= 1'b0;
          rel_q[tail_idx + IDX_W'(j)]     <= 1'b0;
          nonspec_q[tail_idx + IDX_W'(j)] <= alloc_nonspec[j];
          seq_mem[tail_idx + IDX_W'(j)]   <= seq_next_q + SEQ_W'(j);
        end
      end
    end
  end

  // ---------------- outputs ----------------
  assign alloc_idx    = tail_idx;
  assign alloc_seq    = seq_next_q;
  assign retire_cnt   = retire_n;
  assign retire_seq   = seq_mem[head_idx];
  assign nsr_valid    = nsr_valid_q;
  assign nsr_seq      = nsr_seq_q;
  assign free_upd     = free_upd_q;
  assign thread_state = state_q;
  assign active       = (state_q != TS_IDLE);

endmodule

// File: rtl/rob_commit_ctrl_chk.sv
module rob_commit_ctrl_chk
  import rob_commit_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int COMMIT_WIDTH = 2,
  parameter int SQUASH_WIDTH = 3,
  parameter int SEQ_W        = 8,
  localparam int OCC_W  = $clog2(DEPTH) + 1,
  localparam int RCNT_W = $clog2(COMMIT_WIDTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [RCNT_W-1:0] retire_cnt,
  input logic              nsr_valid,
  input logic [2:0]        thread_state,
  input logic [OCC_W-1:0]  free_cnt,
  input logic              free_upd,
  input logic              alloc_ok,
  input logic              active,
  input logic              stores_drained
);

  // R1
  retire_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(retire_cnt) <= COMMIT_WIDTH);

  // R2
  nsr_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nsr_valid |-> (retire_cnt == '0));

  // R3
  nsr_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nsr_valid |=> !nsr_valid);

  // R4
  squash_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thread_state == TS_SQUASH) |=>
      ((free_cnt >= $past(free_cnt)) &&
       (32'(free_cnt) - 32'($past(free_cnt)) <= SQUASH_WIDTH)));

  // R5
  state_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thread_state <= 3'd4);

  // R6
  no_alloc_in_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thread_state == TS_SQUASH) |-> !alloc_ok);

  // R7
  trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((thread_state == TS_TRAP) && !stores_drained) |=> (thread_state == TS_TRAP));

  // R7
  trap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thread_state == TS_TRAP) |-> ((retire_cnt == '0) && !alloc_ok));

  // R8
  free_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_upd == (free_cnt != $past(free_cnt)));

  // R11
  idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (32'(free_cnt) == DEPTH));

endmodule

bind rob_commit_ctrl rob_commit_ctrl_chk #(
  .DEPTH(DEPTH), .COMMIT_WIDTH(COMMIT_WIDTH),
  .SQUASH_WIDTH(SQUASH_WIDTH), .SEQ_W(SEQ_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .retire_cnt(retire_cnt), .nsr_valid(nsr_valid),
  .thread_state(thread_state), .free_cnt(free_cnt), .free_upd(free_upd),
  .alloc_ok(alloc_ok), .active(active), .stores_drained(stores_drained)
);

// File: tb/rob_commit_ctrl_tb.sv
`timescale 1ns/1ps
module rob_commit_ctrl_tb;

  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] alloc_cnt = '0;
  logic [1:0] alloc_nonspec = '0;
  logic       alloc_ok;
  logic [3:0] alloc_idx;
  logic [7:0] alloc_seq;
  logic       cmpl_valid = 1'b0;
  logic [3:0] cmpl_idx = '0;
  logic [1:0] retire_cnt;
  logic [7:0] retire_seq;
  logic       nsr_valid;
  logic [7:0] nsr_seq;
  logic       squash_req = 1'b0, trap_req = 1'b0, ftrap_req = 1'b0;
  logic [3:0] trap_lat = '0;
  logic       stores_drained = 1'b0;
  logic [4:0] free_cnt;
  logic       free_upd;
  logic [2:0] thread_state;
  logic       active;

  always #2 clk = ~clk;

  rob_commit_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .alloc_cnt(alloc_cnt), .alloc_nonspec(alloc_nonspec),
    .alloc_ok(alloc_ok), .alloc_idx(alloc_idx), .alloc_seq(alloc_seq),
    .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx), .retire_cnt(retire_cnt),
    .retire_seq(retire_seq), .nsr_valid(nsr_valid), .nsr_seq(nsr_seq),
    .squash_req(squash_req), .trap_req(trap_req), .trap_lat(trap_lat),
    .stores_drained(stores_drained), .ftrap_req(ftrap_req), .free_cnt(free_cnt),
    .free_upd(free_upd), .thread_state(thread_state), .active(active)
  );

  int n_cmp = 0, n_bad = 0;
  int q[$];
  int idx_of [256];
  int exp_seq = 0, exp_tail = 0, n_ret = 0;
  int n_nsr = 0, last_nsr = -1;
  bit finished = 0;

  task automatic check(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Monitor: pops expected program order as retirements appear.
  initial forever begin
    @(negedge clk); #1;
    if (rst_n) begin
      for (int i = 0; i < int'(retire_cnt); i++) begin
        if (q.size() == 0) check("R1 retire with empty scoreboard", int'(retire_seq) + i, -1);
        else check("R1 retire order", int'(retire_seq) + i, q.pop_front());
        n_ret++;
      end
      if (nsr_valid) begin n_nsr++; last_nsr = int'(nsr_seq); end
    end
  end

  // Driver tasks: called at a falling edge, return at the next falling edge.
  task automatic do_alloc(int n, logic [1:0] ns, bit exp_ok, string tag);
    alloc_cnt = 2'(n); alloc_nonspec = ns; #1;
    check(tag, int'(alloc_ok), int'(exp_ok));
    if (exp_ok && alloc_ok) begin
      check({tag, " seq"}, int'(alloc_seq), exp_seq);
      check({tag, " idx"}, int'(alloc_idx), exp_tail);
      for (int i = 0; i < n; i++) begin
        idx_of[exp_seq] = exp_tail;
        q.push_back(exp_seq);
        exp_seq++;
        exp_tail = (exp_tail + 1) % DEPTH;
      end
    end
    @(negedge clk);
    alloc_cnt = '0; alloc_nonspec = '0;
  endtask

  task automatic do_cmpl(int s);
    cmpl_valid = 1'b1; cmpl_idx = 4'(idx_of[s]);
    @(negedge clk);
    cmpl_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic flushed();
    q.delete();
    exp_tail = n_ret % DEPTH;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      check("watchdog expired", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R5 reset state
    check("R5 reset free_cnt", int'(free_cnt), 16);
    check("R5 reset state idle", int'(thread_state), 0);
    check("R11 reset inactive", int'(active), 0);
    check("R8 reset free_upd", int'(free_upd), 0);
    check("R3 reset nsr", int'(nsr_valid), 0);

    // R6 basic allocation, R8 update strobe
    do_alloc(2, 2'b00, 1, "R6 alloc two");
    check("R8 free after alloc", int'(free_cnt), 14);
    check("R8 strobe on change", int'(free_upd), 1);
    check("R5 running", int'(thread_state), 1);
    idle(1);
    check("R8 strobe quiet", int'(free_upd), 0);

    // R1 out-of-order completion, in-order retirement
    do_cmpl(1);
    check("R1 head incomplete", int'(retire_cnt), 0);
    do_cmpl(0);
    check("R1 two retire", int'(retire_cnt), 2);
    idle(1);
    check("R11 idle after drain", int'(active), 0);
    check("R1 free restored", int'(free_cnt), 16);

    // R1 stop at first gap, width cap
    do_alloc(2, 2'b00, 1, "R6 alloc b1");
    do_alloc(2, 2'b00, 1, "R6 alloc b2");
    do_cmpl(2);
    check("R1 single retire", int'(retire_cnt), 1);
    do_cmpl(4);
    check("R1 gap stops", int'(retire_cnt), 0);
    do_cmpl(5);
    check("R1 gap still stops", int'(retire_cnt), 0);
    do_cmpl(3);
    check("R1 capped at width", int'(retire_cnt), 2);
    idle(1);
    check("R1 remainder", int'(retire_cnt), 1);
    idle(1);

    // R2/R3 non-speculative release at head only
    do_alloc(2, 2'b10, 1, "R6 alloc ns1");
    do_alloc(2, 2'b10, 1, "R6 alloc ns2");
    idle(4);
    check("R2 no release off head", n_nsr, 0);
    do_cmpl(6);
    idle(4);
    check("R3 one release", n_nsr, 1);
    check("R3 release seq", last_nsr, 7);
    check("R2 stalled behind ns", int'(retire_cnt), 0);
    do_cmpl(8);
    idle(3);
    check("R2 younger ns waits", n_nsr, 1);
    do_cmpl(7);
    check("R1 ns and follower retire", int'(retire_cnt), 2);
    idle(4);
    check("R3 second release", n_nsr, 2);
    check("R3 second release seq", last_nsr, 9);
    do_cmpl(9);
    idle(2);
    check("R5 idle again", int'(thread_state), 0);

    // R6 fill to the brim and overflow refusal
    for (int k = 0; k < 7; k++) do_alloc(2, 2'b00, 1, "R6 fill");
    do_alloc(1, 2'b00, 1, "R6 fill last-but-one");
    check("R6 one free", int'(free_cnt), 1);
    do_alloc(2, 2'b00, 0, "R6 refuse over by one");
    check("R6 free unchanged", int'(free_cnt), 1);
    do_alloc(1, 2'b00, 1, "R6 exact fit");
    check("R6 full", int'(free_cnt), 0);
    do_alloc(1, 2'b00, 0, "R6 refuse when full");

    // R4 squash walk, R12 requests ignored while squashing
    squash_req = 1'b1;
    @(negedge clk);
    squash_req = 1'b0;
    check("R4 squashing", int'(thread_state), 2);
    check("R4 nothing removed yet", int'(free_cnt), 0);
    for (int k = 1; k <= 6; k++) begin
      trap_req  = (k == 1);
      alloc_cnt = (k == 2) ? 2'd1 : 2'd0;
      #1;
      if (k == 2) check("R6 no alloc in squash", int'(alloc_ok), 0);
      @(negedge clk);
      trap_req = 1'b0; alloc_cnt = '0;
      check("R4 free during walk", int'(free_cnt), (3 * k > 16) ? 16 : 3 * k);
      check("R12 state during walk", int'(thread_state), (k < 6) ? 2 : 0);
    end
    flushed();

    // R7 trap waits for stores
    do_alloc(2, 2'b00, 1, "R6 alloc t1");
    trap_req = 1'b1; trap_lat = 4'd3; stores_drained = 1'b0;
    @(negedge clk);
    trap_req = 1'b0;
    check("R7 trap pending", int'(thread_state), 3);
    do_cmpl(26);
    do_cmpl(27);
    idle(3);
    check("R7 held without drain", int'(thread_state), 3);
    check("R7 no retire in trap", int'(retire_cnt), 0);
    stores_drained = 1'b1;
    @(negedge clk);
    check("R7 leaves after drain", int'(thread_state), 2);
    idle(1);
    check("R4 trap flush done", int'(thread_state), 0);
    check("R4 trap flush free", int'(free_cnt), 16);
    flushed();

    // R9 trap latency
    do_alloc(1, 2'b00, 1, "R6 alloc t2");
    trap_req = 1'b1; trap_lat = 4'd3;
    @(negedge clk);
    trap_req = 1'b0;
    check("R9 trap taken", int'(thread_state), 3);
    for (int k = 1; k <= 4; k++) begin
      idle(1);
      check("R9 latency edge", int'(thread_state), (k < 4) ? 3 : 2);
    end
    idle(1);
    check("R9 flush complete", int'(thread_state), 0);
    flushed();
    trap_req = 1'b1; trap_lat = 4'd0;
    @(negedge clk);
    trap_req = 1'b0;
    check("R9 zero latency taken", int'(thread_state), 3);
    idle(1);
    check("R9 zero latency squash", int'(thread_state), 2);
    idle(1);
    check("R9 zero latency idle", int'(thread_state), 0);

    // R10 fetch-trap drain
    do_alloc(2, 2'b00, 1, "R6 alloc f1");
    ftrap_req = 1'b1;
    @(negedge clk);
    ftrap_req = 1'b0;
    check("R10 fetch trap state", int'(thread_state), 4);
    do_alloc(1, 2'b00, 0, "R10 alloc refused");
    do_cmpl(29);
    do_cmpl(30);
    idle(2);
    check("R10 back to idle", int'(thread_state), 0);
    check("R11 inactive when empty", int'(active), 0);
    check("R10 scoreboard drained", q.size(), 0);
    check("R10 retired total", n_ret, 12);

    finished = 1;
    summary();
    $finish;
  end

endmodule